// File: doc/BRIEF.md
# 10-bit Addressed I2C Slave Transmitter

This block is the bus-side engine of an I2C target that answers master reads. It takes SCL and SDA samples that are already synchronized to the system clock and finds START, repeated START and STOP. It collects address bytes and decides whether to acknowledge each one. It raises a match status bit with a direction bit, then sends data bytes that software hands over through a load strobe. Outputs `sda_oe` and `scl_oe` are open-drain enables: when high, the pad pulls the line low.

In 10-bit mode a read is a two-step exchange. First the master sends a header byte with the write direction (`11110` in bits 7..3, address bits 9..8 in bits 2..1, bit 0 = 0), followed by the low eight address bits. Then it issues a repeated START and sends the header byte again with bit 0 = 1. The block keeps an internal "armed" bit between the two steps and acknowledges the read header only while that bit is set. In 7-bit mode a single byte carries the address in bits 7..1 and the direction in bit 0. A general-call byte (0x00) can be accepted in either mode.

After a read match the block holds SCL low until software supplies a byte. It does the same after every byte the master acknowledges. A master NACK ends the transfer. One-cycle pulses report whether the transaction closed with STOP or with a repeated START.

Top module: `i2c10_slave_tx`

## Requirements
- R1: With `cfg_ten`=1, a first byte equal to {`11110`, `cfg_addr[9:8]`, 0} is acknowledged (SDA held low during the ninth clock). A first byte with any other upper pattern or address field is left unacknowledged.
- R2: After an acknowledged write header, a second byte equal to `cfg_addr[7:0]` is acknowledged and sets `am_flag` with `dir_rd`=0 and `gc_flag`=0. Any other second byte is not acknowledged and leaves `am_flag` clear.
- R3: A header with bit 0 = 1 is acknowledged only while armed. The block becomes armed when a write header and a matching second byte complete, and it stays armed across further repeated STARTs. An acknowledged read header sets `am_flag` with `dir_rd`=1.
- R4: STOP disarms the block. A read header that follows a STOP without a new write match is not acknowledged.
- R5: With `cfg_ten`=0, a byte whose bits 7..1 equal `cfg_addr[6:0]` is acknowledged and sets `am_flag` with `dir_rd` equal to bit 0. A 10-bit header pattern is not treated specially in this mode.
- R6: With `cfg_gc_en`=1, the byte 0x00 is acknowledged in either mode and sets `am_flag` and `gc_flag`. With `cfg_gc_en`=0 it is not acknowledged.
- R7: A high `stat_rd` clears `am_flag` on the next clock edge. If a new match lands in the same cycle, the set wins. `irq` equals `am_flag`.
- R8: After the acknowledge of a read match, and after each master ACK, `scl_oe` and `tx_req` stay high until `tx_load` is seen. `tx_load` is ignored while `tx_req` is low. SCL is released one cycle after the load.
- R9: Data bytes leave MSB first. `sda_oe` changes only while SCL is low.
- R10: A master ACK on the ninth clock of a data byte leads to a request for the next byte. A NACK releases SDA and SCL, and no further byte is requested.
- R11: `ev_stop` or `ev_restart` pulses for one cycle when STOP or START is seen while a transaction is in progress.
- R12: After a write-direction match, any further byte written by the master is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| cfg_addr | input | 10 | Own address (bits 6..0 used in 7-bit mode) |
| cfg_ten | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| cfg_gc_en | input | 1 | Accept general call 0x00 |
| stat_rd | input | 1 | Status read strobe, clears `am_flag` |
| tx_load | input | 1 | Strobe: `tx_byte` is valid |
| tx_byte | input | 8 | Next byte to transmit |
| sda_oe | output | 1 | Pull SDA low |
| scl_oe | output | 1 | Pull SCL low (waiting for data) |
| tx_req | output | 1 | Block is waiting for `tx_load` |
| am_flag | output | 1 | Address match status |
| dir_rd | output | 1 | Direction of last match, 1 = master reads |
| gc_flag | output | 1 | Last match was a general call |
| irq | output | 1 | Interrupt, follows `am_flag` |
| ev_stop | output | 1 | One-cycle pulse on STOP during a transaction |
| ev_restart | output | 1 | One-cycle pulse on repeated START |

## Verification
Two functions can act on the match flag in the same clock: a software status read clearing it and the address decoder setting it on the eighth SCL rise of a matching byte. The bench holds `stat_rd` high for a whole write-header exchange, so a read strobe is present in exactly the cycle the match lands. It then counts how many cycles `am_flag` is high. Exactly one cycle shows that the set won and that the next read cleared it. Zero cycles means the event was lost.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0]  HDR10_TAG = 5'b11110;
  localparam logic [BYTE_W-1:0] GCALL_BYTE = '0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_DECIDE, ST_ACK, ST_TXWAIT, ST_TX, ST_MACK, ST_IGNORE
  } slv_state_e;

  typedef enum logic { K_FIRST, K_SECOND } rx_kind_e;

  typedef struct packed {
    logic       ack;
    logic       hit;
    logic       dir;
    logic       gcall;
    logic       arm_set;
    logic       arm_clr;
    slv_state_e nxt;
  } dec_t;

  // header byte carries the 10-bit tag in its top five bits
  function automatic logic is_hdr10(input logic [BYTE_W-1:0] b);
    return b[7:3] == HDR10_TAG;
  endfunction

  function automatic logic hdr10_hit(input logic [BYTE_W-1:0] b, input logic [ADDR_W-1:0] a);
    return is_hdr10(b) && (b[2:1] == a[9:8]);
  endfunction

  function automatic logic seven_hit(input logic [BYTE_W-1:0] b, input logic [ADDR_W-1:0] a);
    return b[7:1] == a[6:0];
  endfunction

  function automatic logic gcall_hit(input logic [BYTE_W-1:0] b, input logic en);
    return en && (b == GCALL_BYTE);
  endfunction
endpackage

// File: rtl/i2c10_bus_cond.sv
module i2c10_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  assign scl_rise  = scl_in & ~scl_q;
  assign scl_fall  = ~scl_in & scl_q;
  assign bus_start = scl_in & scl_q & sda_q & ~sda_in;
  assign bus_stop  = scl_in & scl_q & ~sda_q & sda_in;
endmodule

// File: rtl/i2c10_addr_dec.sv
module i2c10_addr_dec
  import i2c10_pkg::*;
(
  input  rx_kind_e          kind,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_ten,
  input  logic              cfg_gc_en,
  input  logic              armed,
  output dec_t              dec
);
  always_comb begin
    dec     = '0;
    dec.nxt = ST_IGNORE;
    if (kind == K_SECOND) begin
      if (rx_byte == cfg_addr[7:0]) begin
        dec.ack     = 1'b1;
        dec.hit     = 1'b1;
        dec.arm_set = 1'b1;
      end
    end else if (gcall_hit(rx_byte, cfg_gc_en)) begin
      dec.ack   = 1'b1;
      dec.hit   = 1'b1;
      dec.gcall = 1'b1;
    end else if (cfg_ten) begin
      if (hdr10_hit(rx_byte, cfg_addr)) begin
        if (!rx_byte[0]) begin
          dec.ack     = 1'b1;
          dec.arm_clr = 1'b1;
          dec.nxt     = ST_RX;
        end else if (armed) begin
          dec.ack = 1'b1;
          dec.hit = 1'b1;
          dec.dir = 1'b1;
          dec.nxt = ST_TXWAIT;
        end
      end
    end else if (seven_hit(rx_byte, cfg_addr)) begin
      dec.ack = 1'b1;
      dec.hit = 1'b1;
      dec.dir = rx_byte[0];
      dec.nxt = rx_byte[0] ? ST_TXWAIT : ST_IGNORE;
    end
  end
endmodule

// File: rtl/i2c10_slave_tx.sv
module i2c10_slave_tx
  import i2c10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_ten,
  input  logic              cfg_gc_en,
  input  logic              stat_rd,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              tx_req,
  output logic              am_flag,
  output logic              dir_rd,
  output logic              gc_flag,
  output logic              irq,
  output logic              ev_stop,
  output logic              ev_restart
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  slv_state_e        state;
  rx_kind_e          kind;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              pend_ack;
  slv_state_e        pend_nxt;
  logic              armed;
  logic              mack;
  logic              su_hold;

  // named events for the checker
  logic scl_rise, scl_fall, bus_start, bus_stop;
  logic byte_done, match_set, load_take;
  logic [BYTE_W-1:0] rx_byte;
  dec_t dec;

  i2c10_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  assign rx_byte = {rx_sh, sda_in};

  i2c10_addr_dec u_dec (
    .kind(kind), .rx_byte(rx_byte), .cfg_addr(cfg_addr),
    .cfg_ten(cfg_ten), .cfg_gc_en(cfg_gc_en), .armed(armed), .dec(dec)
  );

  assign byte_done = (state == ST_RX) && scl_rise && (cnt == LAST_BIT)
                     && !bus_start && !bus_stop;
  assign match_set = byte_done && dec.hit;
  assign load_take = (state == ST_TXWAIT) && tx_load && !bus_start && !bus_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kind       <= K_FIRST;
      cnt        <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      pend_ack   <= 1'b0;
      pend_nxt   <= ST_IGNORE;
      armed      <= 1'b0;
      mack       <= 1'b0;
      su_hold    <= 1'b0;
      ev_stop    <= 1'b0;
      ev_restart <= 1'b0;
    end else begin
      ev_stop    <= 1'b0;
      ev_restart <= 1'b0;
      su_hold    <= load_take;
      if (bus_stop) begin
        ev_stop <= (state != ST_IDLE);
        armed   <= 1'b0;
        state   <= ST_IDLE;
      end else if (bus_start) begin
        ev_restart <= (state != ST_IDLE);
        state      <= ST_RX;
        kind       <= K_FIRST;
        cnt        <= '0;
      end else begin
        case (state)
          ST_RX: if (scl_rise) begin
            rx_sh <= rx_byte[BYTE_W-2:0];
            if (cnt == LAST_BIT) begin
              pend_ack <= dec.ack;
              pend_nxt <= dec.nxt;
              state    <= ST_DECIDE;
              if (dec.arm_clr) armed <= 1'b0;
              if (dec.arm_set) armed <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DECIDE: if (scl_fall) state <= pend_ack ? ST_ACK : ST_IGNORE;
          ST_ACK: if (scl_fall) begin
            state <= pend_nxt;
            kind  <= K_SECOND;
            cnt   <= '0;
          end
          ST_TXWAIT: if (tx_load) begin
            tx_sh <= tx_byte;
            cnt   <= '0;
            state <= ST_TX;
          end
          ST_TX: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == ALL_BITS) state <= ST_MACK;
              else tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
          end
          ST_MACK: begin
            if (scl_rise) mack <= !sda_in;
            else if (scl_fall) state <= mack ? ST_TXWAIT : ST_IGNORE;
          end
          default: ;
        endcase
      end
    end
  end

  // status: a new match outranks a clearing read in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      am_flag <= 1'b0;
      dir_rd  <= 1'b0;
      gc_flag <= 1'b0;
    end else if (match_set) begin
      am_flag <= 1'b1;
      dir_rd  <= dec.dir;
      gc_flag <= dec.gcall;
    end else if (stat_rd) begin
      am_flag <= 1'b0;
    end
  end

  assign sda_oe = (state == ST_ACK) || ((state == ST_TX) && !tx_sh[BYTE_W-1]);
  assign tx_req = (state == ST_TXWAIT);
  assign scl_oe = tx_req || su_hold;
  assign irq    = am_flag;
endmodule

// File: rtl/i2c10_slave_chk.sv
module i2c10_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_oe,
  input logic scl_oe,
  input logic tx_load,
  input logic stat_rd,
  input logic am_flag,
  input logic match_set,
  input logic armed,
  input logic ev_stop
);
  assert_sda_moves_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in);

  assert_scl_freed_by_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> $past(tx_load, 2));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !match_set) |=> !am_flag);

  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match_set |=> am_flag);

  assert_stop_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |-> !armed);
endmodule

bind i2c10_slave_tx i2c10_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .tx_load(tx_load), .stat_rd(stat_rd), .am_flag(am_flag),
  .match_set(match_set), .armed(armed), .ev_stop(ev_stop)
);

// File: tb/tb_i2c10_slave_tx.sv
`timescale 1ns/1ps
module tb_i2c10_slave_tx;
  localparam int H = 8;

  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n;
  logic m_scl = 1, m_sda = 1;
  logic scl_in, sda_in;
  logic [9:0] cfg_addr;
  logic cfg_ten, cfg_gc_en, stat_rd, tx_load;
  logic [7:0] tx_byte;
  logic sda_oe, scl_oe, tx_req, am_flag, dir_rd, gc_flag, irq, ev_stop, ev_restart;

  assign scl_in = m_scl & ~scl_oe;
  assign sda_in = m_sda & ~sda_oe;

  i2c10_slave_tx dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .cfg_addr(cfg_addr), .cfg_ten(cfg_ten), .cfg_gc_en(cfg_gc_en),
    .stat_rd(stat_rd), .tx_load(tx_load), .tx_byte(tx_byte),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .tx_req(tx_req), .am_flag(am_flag),
    .dir_rd(dir_rd), .gc_flag(gc_flag), .irq(irq),
    .ev_stop(ev_stop), .ev_restart(ev_restart)
  );

  int n_checks = 0, n_fail = 0;
  int n_stop = 0, n_restart = 0, am_hi = 0, held = 0;
  bit done = 0;

  // software model: supplies bytes in order when asked
  logic [7:0] sw_q [8] = '{8'hC3, 8'h5A, 8'h81, 8'h3C, 8'h99, 8'hA7, 8'h00, 8'h00};
  int sw_idx = 0, sw_delay = 40, stray_req = 0, stray_done = 0;

  typedef struct packed {
    logic ten; logic gc; logic [9:0] addr; logic [7:0] b1; logic [7:0] b2;
    logic has2; logic a1; logic a2; logic m; logic dir; logic gcf; logic [3:0] tag;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,10'h2A5,8'hF4,8'hA5,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,4'd2},
    '{1'b1,1'b0,10'h2A5,8'hF4,8'hA4,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,4'd2},
    '{1'b1,1'b0,10'h2A5,8'hF2,8'hA5,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd1},
    '{1'b1,1'b0,10'h1C3,8'hF2,8'hC3,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,4'd1},
    '{1'b1,1'b0,10'h2A5,8'hF5,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd4},
    '{1'b0,1'b0,10'h05A,8'hB4,8'h00,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd5},
    '{1'b0,1'b0,10'h05A,8'hB6,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5},
    '{1'b0,1'b0,10'h05A,8'hF4,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5},
    '{1'b0,1'b1,10'h05A,8'h00,8'h00,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'd6},
    '{1'b0,1'b0,10'h05A,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd6},
    '{1'b1,1'b1,10'h2A5,8'h00,8'h00,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'd6},
    '{1'b1,1'b0,10'h2A5,8'hB4,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd1}
  };

  function automatic string req_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd4: return "R4";
      4'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (scl_in !== 1'b1) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1; wclk(H);
    m_scl = 1; wait_scl_high(); wclk(H);
    m_sda = 0; wclk(H);
    m_scl = 0; wclk(H);
  endtask

  task automatic bus_stop();
    m_sda = 0; wclk(H);
    m_scl = 1; wait_scl_high(); wclk(H);
    m_sda = 1; wclk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wclk(H);
      m_scl = 1; wait_scl_high(); wclk(H);
      m_scl = 0;
    end
    m_sda = 1; wclk(H);
    m_scl = 1; wait_scl_high(); wclk(H/2);
    ack = !sda_in; wclk(H/2);
    m_scl = 0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1; wclk(H);
      m_scl = 1; wait_scl_high(); wclk(H/2);
      b[i] = sda_in; wclk(H/2);
      m_scl = 0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1; wclk(H);
    m_scl = 1; wait_scl_high(); wclk(H);
    m_scl = 0; wclk(2);
    m_sda = 1;
  endtask

  task automatic pulse_rd();
    stat_rd = 1; wclk(1); stat_rd = 0; wclk(1);
  endtask

  // software process
  initial begin : sw
    tx_load = 0; tx_byte = 0;
    forever begin
      @(negedge clk);
      if (stray_req != stray_done) begin
        tx_byte = 8'hFF; tx_load = 1; @(negedge clk); tx_load = 0;
        stray_done++;
      end else if (tx_req === 1'b1) begin
        repeat (sw_delay) @(negedge clk);
        tx_byte = sw_q[sw_idx]; tx_load = 1; @(negedge clk); tx_load = 0;
        sw_idx++;
      end
    end
  end

  always @(negedge clk) begin
    if (ev_stop === 1'b1) n_stop++;
    if (ev_restart === 1'b1) n_restart++;
    if (am_flag === 1'b1) am_hi++;
    if (scl_oe === 1'b1) held++;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic a;
    logic [7:0] rb;
    int s0, r0, h0, m0;
    rst_n = 0; stat_rd = 0;
    cfg_addr = 10'h2A5; cfg_ten = 1; cfg_gc_en = 0;
    wclk(5);
    chk("R9", "reset sda_oe", sda_oe, 0);
    chk("R8", "reset scl_oe", scl_oe, 0);
    chk("R7", "reset am_flag", am_flag, 0);
    rst_n = 1; wclk(5);

    // table of address decisions
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      cfg_ten = v.ten; cfg_gc_en = v.gc; cfg_addr = v.addr;
      pulse_rd();
      bus_start();
      send_byte(v.b1, a);
      chk(req_name(v.tag), $sformatf("vec%0d first ack", i), a, v.a1);
      if (v.has2 && v.a1) begin
        send_byte(v.b2, a);
        chk(req_name(v.tag), $sformatf("vec%0d second ack", i), a, v.a2);
      end
      bus_stop();
      chk(req_name(v.tag), $sformatf("vec%0d match", i), am_flag, v.m);
      if (v.m) begin
        chk(req_name(v.tag), $sformatf("vec%0d dir", i), dir_rd, v.dir);
        chk(req_name(v.tag), $sformatf("vec%0d gc", i), gc_flag, v.gcf);
      end
    end

    // full 10-bit read with stretching
    cfg_ten = 1; cfg_gc_en = 0; cfg_addr = 10'h2A5; sw_delay = 40;
    pulse_rd();
    bus_start();
    send_byte(8'hF4, a); chk("R1", "hdr write ack", a, 1);
    send_byte(8'hA5, a); chk("R2", "low addr ack", a, 1);
    chk("R2", "am after write match", am_flag, 1);
    chk("R7", "irq follows flag", irq, 1);
    pulse_rd();
    chk("R7", "read clears flag", am_flag, 0);
    r0 = n_restart;
    bus_start();
    chk("R11", "restart pulse", n_restart - r0, 1);
    send_byte(8'hF5, a); chk("R3", "read hdr ack when armed", a, 1);
    chk("R3", "am after read match", am_flag, 1);
    chk("R3", "dir read", dir_rd, 1);
    h0 = held;
    recv_byte(1, rb); chk("R9", "byte0 msb first", rb, 8'hC3);
    chk("R8", "scl held while waiting", (held - h0) >= 40, 1);
    recv_byte(1, rb); chk("R10", "byte1 after ack", rb, 8'h5A);
    recv_byte(0, rb); chk("R9", "byte2", rb, 8'h81);
    wclk(3*H);
    chk("R10", "no request after nack", tx_req, 0);
    chk("R10", "scl free after nack", scl_oe, 0);
    chk("R10", "sda free after nack", sda_oe, 0);
    chk("R10", "loads used", sw_idx, 3);
    s0 = n_stop;
    bus_stop();
    chk("R11", "stop pulse", n_stop - s0, 1);

    // after STOP the read header alone is refused
    bus_start();
    send_byte(8'hF5, a); chk("R4", "read hdr after stop", a, 0);
    bus_stop();

    // stray load ignored; armed survives repeated restarts
    sw_delay = 5;
    stray_req++;
    wclk(10);
    chk("R8", "stray load ignored", tx_req, 0);
    bus_start();
    send_byte(8'hF4, a);
    send_byte(8'hA5, a);
    bus_start();
    send_byte(8'hF5, a); chk("R3", "read hdr first restart", a, 1);
    recv_byte(0, rb); chk("R8", "stray byte not sent", rb, 8'h3C);
    bus_start();
    send_byte(8'hF5, a); chk("R3", "read hdr second restart", a, 1);
    recv_byte(0, rb); chk("R9", "second read byte", rb, 8'h99);
    bus_stop();

    // write data after a write match is refused
    bus_start();
    send_byte(8'hF4, a);
    send_byte(8'hA5, a);
    send_byte(8'h11, a); chk("R12", "write data nack", a, 0);
    bus_stop();

    // status read coinciding with a new match
    stat_rd = 1; wclk(2);
    m0 = am_hi;
    bus_start();
    send_byte(8'hF4, a);
    send_byte(8'hA5, a);
    wclk(4);
    chk("R7", "set wins over read (cycles high)", am_hi - m0, 1);
    chk("R7", "flag cleared after", am_flag, 0);
    stat_rd = 0;
    bus_stop();

    // 7-bit read
    cfg_ten = 0; cfg_addr = 10'h05A;
    pulse_rd();
    bus_start();
    send_byte(8'hB5, a); chk("R5", "7-bit read ack", a, 1);
    chk("R5", "7-bit dir", dir_rd, 1);
    recv_byte(0, rb); chk("R5", "7-bit read byte", rb, 8'hA7);
    bus_stop();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule